// File: doc/BRIEF.md
# Directory Coherence State Controller

This block is the directory side of a coherence protocol for a small, directly indexed table of cache lines. Cores send load and store requests, each with a requester ID and a line index. The controller looks up the line's directory entry, which holds a state, a dirty bit, an owner ID, a sharer vector and pending information. From that lookup it takes one of three actions. On a miss it sends a memory fetch. For a line held exclusively by another core it forwards the request to that core. For a line it can serve directly it returns a data grant. Memory responses and owner forward-acknowledgements complete a pending transaction, update the entry and produce the grant.

Modified has no state code of its own. An effective Modified line is stored as Exclusive with the dirty bit set. A load forward-acknowledgement moves a line to Shared whether it was effectively Exclusive or effectively Modified, and it keeps the dirty bit. A later load to that line is therefore answered with a grant and not with a second forward. A combinational lookup port shows the entry of any line, including the effective state derived from the state and the dirty bit.

The request, outbound and grant channels are valid/ready. A message moves only in a cycle where valid and ready are both high. The outbound and grant channels each hold one registered message, which stays stable until it is taken. Back-pressure on either channel stalls new requests. The response channel is valid/ready as well, and its ready drops while a grant is waiting. Request ready is low in any of these cases: a response is being offered, either output holds a message, or the addressed line is pending.

Top module: `dir_coh_ctrl`

## Requirements
- R1: After reset every line reads Invalid (effective code 0) with dirty clear, sharers zero and not pending, and both out_valid and gnt_valid are low.
- R2: A request (req_store 0 = load, 1 = store) to an Invalid line sends an outbound message of type 0 (memory load) with out_dst 0, the line index and the requester in out_src. The line becomes pending and no grant is issued.
- R3: A response of type 0 (memory data) to a pending line installs it as Exclusive with owner = requester and sharers = only the requester, with dirty set if the request was a store and clear if it was a load. It clears pending and issues a grant with gnt_excl 1 to the requester.
- R4: A load to an Exclusive line owned by a different core sends an outbound message of type 1 (load forward) to that owner, with no grant, and the line becomes pending.
- R5: A response of type 1 (load forward-acknowledgement) to a pending line sets its state to Shared, whether it was effectively Exclusive or effectively Modified. The owner and dirty bit are kept, the sharer vector becomes the previous owner plus the requester, and a grant with gnt_excl 0 goes to the requester.
- R6: A load to a Shared line is granted at once with gnt_excl 0 and no outbound message, and the requester is added to the sharers.
- R7: A request from the owner of an Exclusive line is granted at once with gnt_excl 1 and no outbound message. A store by the owner sets the dirty bit, and a load by the owner changes nothing.
- R8: A store to an Exclusive line owned by another core sends an outbound message of type 2 (store forward) to the owner. The matching response of type 2 makes the line Exclusive and dirty, with owner and sole sharer set to the requester, and issues a grant with gnt_excl 1.
- R9: A store to a Shared line is granted at once with gnt_excl 1 and no outbound message. The line becomes Exclusive and dirty, with owner and sole sharer set to the requester.
- R10: req_ready is low while the addressed line is pending, while out_valid or gnt_valid is high, or while rsp_valid is high. It is high otherwise.
- R11: Once out_valid or gnt_valid is high, it stays high with its fields unchanged until the matching ready is high at a clock edge, and it drops after that edge.
- R12: A response to a line that is not pending, or a response of type 3, is consumed with no effect on any entry and no grant. rsp_ready equals not gnt_valid.
- R13: The lookup reports the effective state as 0 Invalid, 1 Shared, 2 Exclusive clean or 3 Modified (Exclusive with dirty set). The stored state never takes its reserved code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_store | input | 1 | 0 load, 1 store |
| req_src | input | CW | Requesting core ID |
| req_idx | input | IW | Line index |
| out_valid | output | 1 | Outbound message valid |
| out_ready | input | 1 | Outbound message taken |
| out_type | output | 2 | 0 memory load, 1 load forward, 2 store forward |
| out_dst | output | CW | Owner for a forward, 0 for memory |
| out_idx | output | IW | Line index |
| out_src | output | CW | Original requester |
| gnt_valid | output | 1 | Grant valid |
| gnt_ready | input | 1 | Grant taken |
| gnt_dst | output | CW | Core receiving the grant |
| gnt_idx | output | IW | Line index |
| gnt_excl | output | 1 | 1 exclusive grant, 0 shared grant |
| rsp_valid | input | 1 | Response valid |
| rsp_ready | output | 1 | Response accepted |
| rsp_type | input | 2 | 0 memory data, 1 load ack, 2 store ack, 3 ignored |
| rsp_idx | input | IW | Line index |
| lk_idx | input | IW | Lookup line index |
| lk_eff | output | 2 | Effective state 0 I, 1 S, 2 E, 3 M |
| lk_dirty | output | 1 | Dirty bit |
| lk_owner | output | CW | Owner ID |
| lk_sharers | output | NC | Sharer vector |
| lk_pend | output | 1 | Line has an outstanding transaction |
| lk_pend_src | output | CW | Requester waiting on the line |
| lk_pend_store | output | 1 | Waiting request is a store |

## Verification
Several behaviours are checked by assertions on every cycle. A miss always produces a memory load. A load to a line owned by another core forwards to that owner with no grant. A load forward-acknowledgement yields a shared grant for that line, and a load to a Shared line yields a shared grant with no outbound message. A stray response produces no grant, held outputs stay stable, and the reserved state code never appears. The resulting directory contents need the bench's scenarios. These are the Exclusive-to-Shared and the Modified-to-Shared paths with the dirty bit kept, the merged sharer vector, and the fact that a load after a Modified-to-Shared change is granted and not forwarded. The bench's random request mix over a few colliding lines covers them, together with stall probes against pending lines.

// File: rtl/dir_coh_pkg.sv
package dir_coh_pkg;
  // stored line state codes (3 reserved)
  localparam logic [1:0] ST_INV = 2'd0;
  localparam logic [1:0] ST_SHR = 2'd1;
  localparam logic [1:0] ST_EXC = 2'd2;
  // effective state code reported on the lookup port
  localparam logic [1:0] EFF_MOD = 2'd3;
  // outbound message types
  localparam logic [1:0] OM_MEM_LOAD  = 2'd0;
  localparam logic [1:0] OM_LOAD_FWD  = 2'd1;
  localparam logic [1:0] OM_STORE_FWD = 2'd2;
  // response message types
  localparam logic [1:0] RM_MEM_DATA  = 2'd0;
  localparam logic [1:0] RM_LOAD_ACK  = 2'd1;
  localparam logic [1:0] RM_STORE_ACK = 2'd2;
  localparam logic [1:0] RM_NONE      = 2'd3;

  function automatic logic [1:0] eff_state(input logic [1:0] st, input logic dirty);
    eff_state = (st == ST_EXC && dirty) ? EFF_MOD : st;
  endfunction
endpackage

// File: rtl/dir_table.sv
module dir_table #(
  parameter int DEPTH = 16,
  parameter int W     = 12,
  parameter int NRD   = 3,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [IW-1:0]            widx,
  input  logic [W-1:0]             wdata,
  input  logic [NRD-1:0][IW-1:0]   rd_idx,
  output logic [NRD-1:0][W-1:0]    rd_data
);
  logic [W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n)                         mem[g] <= '0;
      else if (we && widx == IW'(g))      mem[g] <= wdata;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_data[r] = mem[rd_idx[r]];
  end
endmodule

// File: rtl/dir_slot.sv
module dir_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (ld) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(dout)); // R11
  AST_SLOT_NO_CLOBBER: assert property (@(posedge clk) disable iff (!rst_n)
    ld |-> !valid); // R10
endmodule

// File: rtl/dir_policy.sv
module dir_policy import dir_coh_pkg::*; #(
  parameter int NL = 16,
  parameter int NC = 4,
  localparam int IW   = $clog2(NL),
  localparam int CW   = $clog2(NC),
  localparam int O_DT = 2,
  localparam int O_OW = 3,
  localparam int O_SH = O_OW + CW,
  localparam int O_PD = O_SH + NC,
  localparam int O_PS = O_PD + 1,
  localparam int O_PT = O_PS + CW,
  localparam int EW   = O_PT + 1
) (
  input  logic          req_fire,
  input  logic          req_store,
  input  logic [CW-1:0] req_src,
  input  logic [IW-1:0] req_idx,
  input  logic [EW-1:0] req_ent,
  input  logic          rsp_fire,
  input  logic [1:0]    rsp_type,
  input  logic [IW-1:0] rsp_idx,
  input  logic [EW-1:0] rsp_ent,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [EW-1:0] wr_ent,
  output logic          out_ld,
  output logic [1:0]    out_type,
  output logic [CW-1:0] out_dst,
  output logic [IW-1:0] out_idx,
  output logic [CW-1:0] out_src,
  output logic          gnt_ld,
  output logic [CW-1:0] gnt_dst,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_excl
);
  function automatic logic [NC-1:0] oh(input logic [CW-1:0] i);
    oh    = '0;
    oh[i] = 1'b1;
  endfunction

  logic [EW-1:0] ent;
  logic [1:0]    n_st;
  logic          n_dt, n_pd, n_pt;
  logic [CW-1:0] n_ow, n_ps;
  logic [NC-1:0] n_sh;

  always_comb begin
    ent      = rsp_fire ? rsp_ent : req_ent;
    n_st     = ent[1:0];
    n_dt     = ent[O_DT];
    n_ow     = ent[O_OW +: CW];
    n_sh     = ent[O_SH +: NC];
    n_pd     = ent[O_PD];
    n_ps     = ent[O_PS +: CW];
    n_pt     = ent[O_PT];
    wr_en    = 1'b0;
    wr_idx   = rsp_fire ? rsp_idx : req_idx;
    out_ld   = 1'b0;
    out_type = OM_MEM_LOAD;
    out_dst  = '0;
    out_idx  = req_idx;
    out_src  = req_src;
    gnt_ld   = 1'b0;
    gnt_dst  = req_src;
    gnt_idx  = req_idx;
    gnt_excl = 1'b0;

    if (rsp_fire) begin
      gnt_dst = n_ps;
      gnt_idx = rsp_idx;
      if (n_pd && rsp_type != RM_NONE) begin
        wr_en  = 1'b1;
        gnt_ld = 1'b1;
        n_pd   = 1'b0;
        case (rsp_type)
          RM_MEM_DATA: begin
            n_st = ST_EXC; n_dt = n_pt; n_ow = n_ps; n_sh = oh(n_ps);
            gnt_excl = 1'b1;
          end
          RM_LOAD_ACK: begin
            // effective E and effective M both drop to Shared, dirty retained
            n_st = ST_SHR; n_sh = oh(n_ow) | oh(n_ps);
            gnt_excl = 1'b0;
          end
          default: begin
            n_st = ST_EXC; n_dt = 1'b1; n_ow = n_ps; n_sh = oh(n_ps);
            gnt_excl = 1'b1;
          end
        endcase
      end
    end else if (req_fire) begin
      wr_en = 1'b1;
      case (n_st)
        ST_SHR: begin
          gnt_ld = 1'b1;
          if (req_store) begin
            n_st = ST_EXC; n_dt = 1'b1; n_ow = req_src; n_sh = oh(req_src);
            gnt_excl = 1'b1;
          end else begin
            n_sh = n_sh | oh(req_src);
          end
        end
        ST_EXC: begin
          if (n_ow == req_src) begin
            gnt_ld   = 1'b1;
            gnt_excl = 1'b1;
            if (req_store) n_dt = 1'b1;
          end else begin
            out_ld   = 1'b1;
            out_type = req_store ? OM_STORE_FWD : OM_LOAD_FWD;
            out_dst  = n_ow;
            n_pd = 1'b1; n_ps = req_src; n_pt = req_store;
          end
        end
        default: begin
          out_ld   = 1'b1;
          out_type = OM_MEM_LOAD;
          n_pd = 1'b1; n_ps = req_src; n_pt = req_store;
        end
      endcase
    end
    wr_ent = {n_pt, n_ps, n_pd, n_sh, n_ow, n_dt, n_st};
  end

  always_comb begin
    AST_SINGLE_OUTCOME: assert (!(out_ld && gnt_ld)); // R2
  end
endmodule

// File: rtl/dir_coh_ctrl.sv
module dir_coh_ctrl import dir_coh_pkg::*; #(
  parameter int NL = 16,
  parameter int NC = 4,
  localparam int IW   = $clog2(NL),
  localparam int CW   = $clog2(NC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_store,
  input  logic [CW-1:0] req_src,
  input  logic [IW-1:0] req_idx,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [1:0]    out_type,
  output logic [CW-1:0] out_dst,
  output logic [IW-1:0] out_idx,
  output logic [CW-1:0] out_src,
  output logic          gnt_valid,
  input  logic          gnt_ready,
  output logic [CW-1:0] gnt_dst,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_excl,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [1:0]    rsp_type,
  input  logic [IW-1:0] rsp_idx,
  input  logic [IW-1:0] lk_idx,
  output logic [1:0]    lk_eff,
  output logic          lk_dirty,
  output logic [CW-1:0] lk_owner,
  output logic [NC-1:0] lk_sharers,
  output logic          lk_pend,
  output logic [CW-1:0] lk_pend_src,
  output logic          lk_pend_store
);
  localparam int O_DT = 2;
  localparam int O_OW = 3;
  localparam int O_SH = O_OW + CW;
  localparam int O_PD = O_SH + NC;
  localparam int O_PS = O_PD + 1;
  localparam int O_PT = O_PS + CW;
  localparam int EW   = O_PT + 1;
  localparam int OW_W = 2 + CW + IW + CW;
  localparam int GW_W = 1 + IW + CW;

  logic [2:0][IW-1:0] rd_idx;
  logic [2:0][EW-1:0] rd_ent;
  logic               wr_en;
  logic [IW-1:0]      wr_idx;
  logic [EW-1:0]      wr_ent;
  logic               req_fire, rsp_fire, out_ld, gnt_ld;
  logic [1:0]         n_otype;
  logic [CW-1:0]      n_odst, n_osrc, n_gdst;
  logic [IW-1:0]      n_oidx, n_gidx;
  logic               n_gexcl;
  logic [EW-1:0]      req_ent, rsp_ent, lk_ent;

  assign rd_idx  = {lk_idx, rsp_idx, req_idx};
  assign req_ent = rd_ent[0];
  assign rsp_ent = rd_ent[1];
  assign lk_ent  = rd_ent[2];

  dir_table #(.DEPTH(NL), .W(EW), .NRD(3)) u_table (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .widx(wr_idx), .wdata(wr_ent),
    .rd_idx(rd_idx), .rd_data(rd_ent)
  );

  assign req_ready = !req_ent[O_PD] && !out_valid && !gnt_valid && !rsp_valid;
  assign rsp_ready = !gnt_valid;
  assign req_fire  = req_valid && req_ready;
  assign rsp_fire  = rsp_valid && rsp_ready;

  dir_policy #(.NL(NL), .NC(NC)) u_policy (
    .req_fire(req_fire), .req_store(req_store), .req_src(req_src), .req_idx(req_idx),
    .req_ent(req_ent), .rsp_fire(rsp_fire), .rsp_type(rsp_type), .rsp_idx(rsp_idx),
    .rsp_ent(rsp_ent), .wr_en(wr_en), .wr_idx(wr_idx), .wr_ent(wr_ent),
    .out_ld(out_ld), .out_type(n_otype), .out_dst(n_odst), .out_idx(n_oidx),
    .out_src(n_osrc), .gnt_ld(gnt_ld), .gnt_dst(n_gdst), .gnt_idx(n_gidx),
    .gnt_excl(n_gexcl)
  );

  dir_slot #(.W(OW_W)) u_out_slot (
    .clk(clk), .rst_n(rst_n), .ld(out_ld), .din({n_otype, n_odst, n_oidx, n_osrc}),
    .ready(out_ready), .valid(out_valid), .dout({out_type, out_dst, out_idx, out_src})
  );

  dir_slot #(.W(GW_W)) u_gnt_slot (
    .clk(clk), .rst_n(rst_n), .ld(gnt_ld), .din({n_gexcl, n_gidx, n_gdst}),
    .ready(gnt_ready), .valid(gnt_valid), .dout({gnt_excl, gnt_idx, gnt_dst})
  );

  assign lk_eff        = eff_state(lk_ent[1:0], lk_ent[O_DT]);
  assign lk_dirty      = lk_ent[O_DT];
  assign lk_owner      = lk_ent[O_OW +: CW];
  assign lk_sharers    = lk_ent[O_SH +: NC];
  assign lk_pend       = lk_ent[O_PD];
  assign lk_pend_src   = lk_ent[O_PS +: CW];
  assign lk_pend_store = lk_ent[O_PT];

  logic [1:0]    req_st;
  logic [CW-1:0] req_own;
  logic          rsp_pend;
  assign req_st   = req_ent[1:0];
  assign req_own  = req_ent[O_OW +: CW];
  assign rsp_pend = rsp_ent[O_PD];

  AST_MISS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && req_st == ST_INV |=> out_valid && out_type == OM_MEM_LOAD && out_idx == $past(req_idx) && !gnt_valid); // R2
  AST_FWD_TO_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && !req_store && req_st == ST_EXC && req_own != req_src |=> out_valid && out_type == OM_LOAD_FWD && out_dst == $past(req_own) && !gnt_valid); // R4
  AST_LDACK_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire && rsp_type == RM_LOAD_ACK && rsp_pend |=> gnt_valid && !gnt_excl && gnt_idx == $past(rsp_idx)); // R5
  AST_SHARED_LOAD_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && !req_store && req_st == ST_SHR |=> gnt_valid && !gnt_excl && !out_valid); // R6
  AST_STRAY_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire && (!rsp_pend || rsp_type == RM_NONE) |=> !gnt_valid); // R12
  AST_NO_RSV_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_ent[1:0] != 2'd3); // R13
endmodule

// File: tb/dir_coh_ctrl_bench.sv
`timescale 1ns/1ps
module dir_coh_ctrl_bench;
  localparam int NL = 16;
  localparam int NC = 4;
  localparam int IW = $clog2(NL);
  localparam int CW = $clog2(NC);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_store = 0, out_ready = 0, gnt_ready = 0, rsp_valid = 0;
  logic [CW-1:0] req_src = '0;
  logic [IW-1:0] req_idx = '0, rsp_idx = '0, lk_idx = '0;
  logic [1:0] rsp_type = '0;
  logic req_ready, out_valid, gnt_valid, gnt_excl, rsp_ready;
  logic [1:0] out_type, lk_eff;
  logic [CW-1:0] out_dst, out_src, gnt_dst, lk_owner, lk_pend_src;
  logic [IW-1:0] out_idx, gnt_idx;
  logic lk_dirty, lk_pend, lk_pend_store;
  logic [NC-1:0] lk_sharers;

  always #10 clk = ~clk;

  dir_coh_ctrl #(.NL(NL), .NC(NC)) u_dir_coh_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_store(req_store), .req_src(req_src), .req_idx(req_idx),
    .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type), .out_dst(out_dst),
    .out_idx(out_idx), .out_src(out_src), .gnt_valid(gnt_valid), .gnt_ready(gnt_ready),
    .gnt_dst(gnt_dst), .gnt_idx(gnt_idx), .gnt_excl(gnt_excl), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_type(rsp_type), .rsp_idx(rsp_idx), .lk_idx(lk_idx),
    .lk_eff(lk_eff), .lk_dirty(lk_dirty), .lk_owner(lk_owner), .lk_sharers(lk_sharers),
    .lk_pend(lk_pend), .lk_pend_src(lk_pend_src), .lk_pend_store(lk_pend_store)
  );

  int n_chk = 0, n_fail = 0;
  int m_st [NL];
  int m_dt [NL];
  int m_ow [NL];
  logic [NC-1:0] m_sh [NL];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic logic [NC-1:0] oneh(input int i);
    oneh = '0;
    oneh[i] = 1'b1;
  endfunction

  function automatic int exp_eff(input int idx);
    exp_eff = (m_st[idx] == 2 && m_dt[idx] != 0) ? 3 : m_st[idx];
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic look(input int idx, input string rq);
    lk_idx = IW'(idx);
    #1;
    chk(lk_eff == 2'(exp_eff(idx)), {rq, " R13 effective state"}, lk_eff, exp_eff(idx));
    chk(lk_dirty == m_dt[idx][0], {rq, " dirty"}, lk_dirty, m_dt[idx]);
    chk(lk_sharers == m_sh[idx], {rq, " sharers"}, lk_sharers, m_sh[idx]);
    chk(!lk_pend, {rq, " R10 pending cleared"}, lk_pend, 0);
    if (m_st[idx] != 0)
      chk(lk_owner == CW'(m_ow[idx]), {rq, " owner"}, lk_owner, m_ow[idx]);
  endtask

  // one complete transaction, model updated from the requirements
  task automatic txn(input bit st, input int src, input int idx, input int hold, input bit bogus);
    bit outb = 0, excl = 0;
    int otype = 0, odst = 0;
    string tg;
    @(negedge clk);
    req_valid = 1; req_store = st; req_src = CW'(src); req_idx = IW'(idx);
    #1;
    chk(req_ready, "R10 ready when idle", req_ready, 1);
    if (m_st[idx] == 0) begin
      outb = 1; otype = 0; odst = 0; tg = "R2";
    end else if (m_st[idx] == 2 && m_ow[idx] != src) begin
      outb = 1; otype = st ? 2 : 1; odst = m_ow[idx]; tg = st ? "R8" : "R4";
    end else if (m_st[idx] == 1) begin
      if (st) begin
        m_st[idx] = 2; m_dt[idx] = 1; m_ow[idx] = src; m_sh[idx] = oneh(src); excl = 1; tg = "R9";
      end else begin
        m_sh[idx] = m_sh[idx] | oneh(src); excl = 0; tg = "R6";
      end
    end else begin
      if (st) m_dt[idx] = 1;
      excl = 1; tg = "R7";
    end
    @(negedge clk);
    req_valid = 0;
    if (outb) begin
      chk(out_valid, {tg, " out_valid"}, out_valid, 1);
      chk(!gnt_valid, {tg, " no grant"}, gnt_valid, 0);
      chk(out_type == 2'(otype), {tg, " out_type"}, out_type, otype);
      chk(out_dst == CW'(odst), {tg, " out_dst"}, out_dst, odst);
      chk(out_idx == IW'(idx) && out_src == CW'(src), {tg, " out idx/src"}, out_idx, idx);
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        chk(out_valid && out_type == 2'(otype) && out_dst == CW'(odst), "R11 out held", out_valid, 1);
      end
      out_ready = 1;
      @(negedge clk);
      out_ready = 0;
      chk(!out_valid, "R11 out dropped after take", out_valid, 0);
      req_valid = 1; req_idx = IW'(idx); req_src = CW'((src + 1) % NC);
      #1;
      chk(!req_ready, "R10 pending line stalls", req_ready, 0);
      req_valid = 0;
      if (bogus) begin
        rsp_valid = 1; rsp_type = 2'd3; rsp_idx = IW'(idx);
        @(negedge clk);
        rsp_valid = 0;
        chk(!gnt_valid, "R12 type 3 ignored", gnt_valid, 0);
        lk_idx = IW'(idx);
        #1;
        chk(lk_pend, "R12 type 3 leaves line pending", lk_pend, 1);
      end
      rsp_valid = 1; rsp_type = 2'(otype); rsp_idx = IW'(idx);
      @(negedge clk);
      rsp_valid = 0;
      if (otype == 0) begin
        m_st[idx] = 2; m_dt[idx] = st; m_ow[idx] = src; m_sh[idx] = oneh(src); excl = 1; tg = "R3";
      end else if (otype == 1) begin
        m_st[idx] = 1; m_sh[idx] = oneh(m_ow[idx]) | oneh(src); excl = 0; tg = "R5";
      end else begin
        m_st[idx] = 2; m_dt[idx] = 1; m_ow[idx] = src; m_sh[idx] = oneh(src); excl = 1; tg = "R8";
      end
    end else begin
      chk(!out_valid, {tg, " no outbound"}, out_valid, 0);
    end
    chk(gnt_valid, {tg, " gnt_valid"}, gnt_valid, 1);
    chk(gnt_dst == CW'(src) && gnt_idx == IW'(idx), {tg, " grant dst/idx"}, gnt_dst, src);
    chk(gnt_excl == excl, {tg, " gnt_excl"}, gnt_excl, excl);
    if (hold > 0) begin
      req_valid = 1; req_idx = IW'((idx + 5) % NL);
      #1;
      chk(!req_ready, "R10 stall while grant waits", req_ready, 0);
      req_valid = 0;
      chk(!rsp_ready, "R12 rsp_ready low while grant waits", rsp_ready, 0);
      @(negedge clk);
      chk(gnt_valid && gnt_excl == excl && gnt_dst == CW'(src), "R11 grant held", gnt_valid, 1);
    end
    gnt_ready = 1;
    @(negedge clk);
    gnt_ready = 0;
    chk(!gnt_valid, "R11 grant dropped after take", gnt_valid, 0);
    look(idx, tg);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NL; i++) begin
      m_st[i] = 0; m_dt[i] = 0; m_ow[i] = 0; m_sh[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!out_valid && !gnt_valid, "R1 outputs idle", out_valid, 0);
    for (int i = 0; i < NL; i++) look(i, "R1");

    // E clean -> S via load forward-acknowledgement
    txn(0, 1, 5, 1, 0);
    txn(0, 2, 5, 0, 1);
    // M (E + dirty) -> S, dirty kept; next load is a grant
    txn(1, 0, 6, 2, 0);
    txn(0, 3, 6, 1, 1);
    txn(0, 2, 6, 0, 0);
    // owner load and store, then store upgrade from Shared, store forward
    txn(0, 1, 7, 0, 0);
    txn(0, 1, 7, 0, 0);
    txn(1, 1, 7, 1, 0);
    txn(1, 3, 5, 0, 0);
    txn(1, 2, 5, 1, 0);

    // stray response to a line that is not pending
    @(negedge clk);
    rsp_valid = 1; rsp_type = 2'd0; rsp_idx = IW'(9);
    #1;
    chk(rsp_ready, "R12 rsp_ready with no grant", rsp_ready, 1);
    @(negedge clk);
    rsp_valid = 0;
    chk(!gnt_valid && !out_valid, "R12 stray response ignored", gnt_valid, 0);
    look(9, "R12");

    for (int n = 0; n < 300; n++)
      txn(1'($urandom % 2), int'($urandom % NC), int'($urandom % 4),
          int'($urandom % 3), ($urandom % 4) == 0);

    summary();
    $finish;
  end
endmodule